// File: doc/BRIEF.md
# Input Capture Edge Counter and Timer

This block watches one external input line and turns its transitions into counts or time stamps. The line is brought into the clock domain through a chain of synchronizing flops. A transition is then qualified against a selectable active edge: rising, falling, both, or none. A single 24-bit counter serves both behaviours. Its lower 16 bits are the main counter. Its upper 8 bits are a prescaler that receives the carry out of the lower field.

In edge-count mode the counter starts from a programmed load value and steps by one on each qualifying edge. When the next step would reach the programmed match value, the block raises a one-cycle match pulse instead and reloads the load value. In edge-time mode the counter free-runs at one step per clock. Each qualifying edge latches the count into a capture register and raises a one-cycle event pulse.

A three-state controller sequences the block:

- ST_IDLE is the state while the enable is low. It holds the counter and capture register.
- ST_IDLE moves to ST_COUNT when the enable is high with the mode input low. The counter is loaded with the load value.
- ST_IDLE moves to ST_TIME when the enable is high with the mode input high. The counter is cleared.
- ST_COUNT returns to ST_IDLE when the enable drops or the mode input goes high.
- ST_TIME returns to ST_IDLE when the enable drops or the mode input goes low.

Any change of mode therefore passes through ST_IDLE for one cycle.

Top module: `edge_capture_timer`

## Requirements
- R1: While reset is asserted and right after it, count_word and capture_word read 0 and both pulse outputs are low.
- R2: The input passes through two synchronizing flops and an edge register. A level on cap_in sampled at clock edge k acts at clock edge k+2. At most one edge is taken per clock.
- R3: edge_sel value 0 takes rising edges, value 1 takes falling edges, and value 3 takes both edges.
- R4: edge_sel value 2 takes no edge. In either mode, transitions of cap_in then change neither the counter nor the capture register, and raise no pulse.
- R5: Entering count mode (time_mode = 0) from idle loads load_val into the counter. Each qualifying edge then adds one.
- R6: In count mode, if adding one would make the counter equal match_val, match_pulse is high for one cycle and the counter reloads load_val instead.
- R7: Entering time mode (time_mode = 1) from idle clears the counter. The counter then adds one on every clock while the block stays in that mode.
- R8: In time mode, a qualifying edge copies the counter value held before that clock edge into capture_word, and event_pulse is high for one cycle.
- R9: The 24-bit count is exposed with the main counter in bits 15:0 and the prescaler in bits 23:16. A carry out of bits 15:0 increments bits 23:16. Bits 31:24 of count_word and capture_word are always 0.
- R10: While enable is low, the counter and capture register hold and no pulse occurs. A mode change while enabled goes through idle and re-enters with a fresh load or clear.
- R11: match_pulse only occurs in count mode and event_pulse only in time mode. The two pulses are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel enable; capture logic runs only while high |
| time_mode | input | 1 | 0 = edge-count mode, 1 = edge-time mode |
| edge_sel | input | 2 | Active edge: 0 rising, 1 falling, 2 none, 3 both |
| load_val | input | 24 | Start and reload value in count mode |
| match_val | input | 24 | Value that ends a count cycle |
| cap_in | input | 1 | External input line, asynchronous |
| match_pulse | output | 1 | One-cycle pulse when the count reaches match_val |
| event_pulse | output | 1 | One-cycle pulse when a time stamp is captured |
| count_word | output | 32 | Running count, prescaler in bits 23:16 |
| capture_word | output | 32 | Last captured time stamp, prescaler in bits 23:16 |

## Verification
The assertions assume that reset is applied before the first checked edge. They also assume that load_val is stable between the edge that sets a match and the next edge, because the reload check compares against the value one clock earlier. The stimulus changes configuration only at the inactive clock edge and holds cap_in levels for several clocks. Every pulse it generates is therefore a clean, synchronizable transition. Mode and edge-select changes are made with the input at rest, so the reference model and the design both see a stable qualifying condition.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int CNT_LOW_W = 16;
    localparam int CNT_PRE_W = 8;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_NONE = 2'd2,
        EDGE_ANY  = 2'd3
    } edge_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_TIME  = 2'd2
    } cap_state_e;

endpackage

// File: rtl/cap_edge_detect.sv
module cap_edge_detect
    import cap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      din,
    input  edge_sel_e sel,
    output logic      edge_hit
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   synced;
    logic                   prev_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
            end
        end
    endgenerate

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= synced;
    end

    always_comb begin
        unique case (sel)
            EDGE_RISE: edge_hit = synced & ~prev_q;
            EDGE_FALL: edge_hit = ~synced & prev_q;
            EDGE_ANY:  edge_hit = synced ^ prev_q;
            default:   edge_hit = 1'b0;
        endcase
    end

    // R2: an accepted edge always coincides with a change of the synchronized level
    assert_edge_needs_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |-> (synced != prev_q));

    // R4: the reserved code never yields an edge
    assert_none_code_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == EDGE_NONE) |-> !edge_hit);

endmodule

// File: rtl/cap_counter.sv
module cap_counter #(
    parameter int LOW_W = 16,
    parameter int PRE_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [LOW_W+PRE_W-1:0] load_data,
    input  logic                   step,
    output logic [LOW_W+PRE_W-1:0] value,
    output logic [LOW_W+PRE_W-1:0] value_inc
);

    localparam int CNT_W = LOW_W + PRE_W;
    localparam logic [LOW_W-1:0] LOW_ONE = 1;

    logic [LOW_W-1:0] low_q;
    logic [PRE_W-1:0] pre_q;
    logic [LOW_W-1:0] low_nx;
    logic [PRE_W-1:0] pre_nx;
    logic             carry;

    assign carry  = &low_q;
    assign low_nx = low_q + LOW_ONE;
    assign pre_nx = pre_q + {{(PRE_W-1){1'b0}}, carry};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q <= '0;
            pre_q <= '0;
        end else if (load) begin
            low_q <= load_data[LOW_W-1:0];
            pre_q <= load_data[CNT_W-1:LOW_W];
        end else if (step) begin
            low_q <= low_nx;
            pre_q <= pre_nx;
        end
    end

    assign value     = {pre_q, low_q};
    assign value_inc = {pre_nx, low_nx};

    // R9: the prescaler moves only on a carry out of the low field
    assert_prescale_on_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !carry) |=> (pre_q == $past(pre_q)));

endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer
    import cap_pkg::*;
#(
    parameter int LOW_W       = CNT_LOW_W,
    parameter int PRE_W       = CNT_PRE_W,
    parameter int OUT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   enable,
    input  logic                   time_mode,
    input  logic [1:0]             edge_sel,
    input  logic [LOW_W+PRE_W-1:0] load_val,
    input  logic [LOW_W+PRE_W-1:0] match_val,
    input  logic                   cap_in,
    output logic                   match_pulse,
    output logic                   event_pulse,
    output logic [OUT_W-1:0]       count_word,
    output logic [OUT_W-1:0]       capture_word
);

    localparam int CNT_W = LOW_W + PRE_W;
    localparam int PAD_W = OUT_W - CNT_W;

    cap_state_e       state_q, state_nx;
    logic             hit;
    logic [CNT_W-1:0] cnt, cnt_inc, cnt_load_val, cap_q;
    logic             cnt_load, cnt_step, do_match, do_capture;

    cap_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (cap_in),
        .sel      (edge_sel_e'(edge_sel)),
        .edge_hit (hit)
    );

    cap_counter #(.LOW_W(LOW_W), .PRE_W(PRE_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cnt_load),
        .load_data (cnt_load_val),
        .step      (cnt_step),
        .value     (cnt),
        .value_inc (cnt_inc)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // next state and datapath control
    always_comb begin
        state_nx     = state_q;
        cnt_load     = 1'b0;
        cnt_load_val = load_val;
        cnt_step     = 1'b0;
        do_match     = 1'b0;
        do_capture   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (enable) begin
                    state_nx     = time_mode ? ST_TIME : ST_COUNT;
                    cnt_load     = 1'b1;
                    cnt_load_val = time_mode ? '0 : load_val;
                end
            end
            ST_COUNT: begin
                if (!enable || time_mode) begin
                    state_nx = ST_IDLE;
                end else if (hit) begin
                    if (cnt_inc == match_val) begin
                        do_match = 1'b1;
                        cnt_load = 1'b1;
                    end else begin
                        cnt_step = 1'b1;
                    end
                end
            end
            ST_TIME: begin
                if (!enable || !time_mode) begin
                    state_nx = ST_IDLE;
                end else begin
                    cnt_step   = 1'b1;
                    do_capture = hit;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_pulse <= 1'b0;
            event_pulse <= 1'b0;
            cap_q       <= '0;
        end else begin
            match_pulse <= do_match;
            event_pulse <= do_capture;
            if (do_capture) cap_q <= cnt;
        end
    end

    assign count_word   = {{PAD_W{1'b0}}, cnt};
    assign capture_word = {{PAD_W{1'b0}}, cap_q};

    // R10: a disabled channel produces no pulse on the following cycle
    assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!match_pulse && !event_pulse));

    // R6: a match leaves the counter at the reload value
    assert_reload_on_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> (count_word[CNT_W-1:0] == $past(load_val)));

    // R8: a time stamp holds the count seen before the capturing edge
    assert_capture_pre_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        event_pulse |-> (capture_word[CNT_W-1:0] == $past(count_word[CNT_W-1:0])));

    // R11: the two pulse kinds are exclusive
    assert_pulses_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(match_pulse && event_pulse));

endmodule

// File: tb/edge_capture_timer_tb.sv
module edge_capture_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable, time_mode, cap_in;
    logic [1:0]  edge_sel;
    logic [23:0] load_val, match_val;
    logic        match_pulse, event_pulse;
    logic [31:0] count_word, capture_word;

    int tests = 0;
    int fails = 0;
    int mp_seen = 0;
    int ep_seen = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    edge_capture_timer u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .time_mode(time_mode),
        .edge_sel(edge_sel), .load_val(load_val), .match_val(match_val),
        .cap_in(cap_in), .match_pulse(match_pulse), .event_pulse(event_pulse),
        .count_word(count_word), .capture_word(capture_word)
    );

    // behavioural reference model
    bit          hist[$];
    int          m_mode;      // 0 idle, 1 counting, 2 timing
    logic [23:0] m_cnt, m_cap;
    bit          m_mp, m_ep;

    always @(posedge clk) begin
        bit now_l, old_l, take;
        logic [23:0] nx;
        if (!rst_n) begin
            hist = '{0, 0, 0};
            m_mode = 0; m_cnt = '0; m_cap = '0; m_mp = 0; m_ep = 0;
        end else begin
            hist.push_back(cap_in);
            now_l = hist[hist.size()-3];
            old_l = hist[hist.size()-4];
            if (hist.size() > 8) void'(hist.pop_front());
            case (edge_sel)
                2'd0: take = now_l && !old_l;
                2'd1: take = !now_l && old_l;
                2'd3: take = now_l != old_l;
                default: take = 0;
            endcase
            m_mp = 0; m_ep = 0;
            if (m_mode == 0) begin
                if (enable) begin
                    m_mode = time_mode ? 2 : 1;
                    m_cnt  = time_mode ? 24'd0 : load_val;
                end
            end else if (m_mode == 1) begin
                if (!enable || time_mode) m_mode = 0;
                else if (take) begin
                    nx = m_cnt + 24'd1;
                    if (nx == match_val) begin m_mp = 1; m_cnt = load_val; end
                    else m_cnt = nx;
                end
            end else begin
                if (!enable || !time_mode) m_mode = 0;
                else begin
                    if (take) begin m_cap = m_cnt; m_ep = 1; end
                    m_cnt = m_cnt + 24'd1;
                end
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R6 match_pulse", {31'd0, match_pulse}, {31'd0, m_mp});
            chk("R8 event_pulse", {31'd0, event_pulse}, {31'd0, m_ep});
            chk("R5 count_word", count_word, {8'd0, m_cnt});
            chk("R8 capture_word", capture_word, {8'd0, m_cap});
            if (match_pulse) mp_seen++;
            if (event_pulse) ep_seen++;
        end
    end

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(int n);
        for (int i = 0; i < n; i++) begin
            cap_in = 1'b1; wait_n(3);
            cap_in = 1'b0; wait_n(3);
        end
        wait_n(4);
    endtask

    initial begin
        logic [31:0] a;
        rst_n = 0; enable = 0; time_mode = 0; cap_in = 0; edge_sel = 2'd0;
        load_val = 24'd5; match_val = 24'd9;
        wait_n(3);
        chk("R1 count reset", count_word, 32'd0);
        chk("R1 capture reset", capture_word, 32'd0);
        chk("R1 pulses reset", {30'd0, match_pulse, event_pulse}, 32'd0);
        rst_n = 1;
        wait_n(1);
        chk("R1 count after reset", count_word, 32'd0);

        // count mode, rising edges
        enable = 1; wait_n(3);
        chk("R5 load on entry", count_word, 32'd5);
        pulse(3);
        chk("R5 three rising edges", count_word, 32'd8);
        chk("R2 one step per edge", count_word, 32'd8);
        mp_seen = 0;
        pulse(1);
        chk("R6 reload after match", count_word, 32'd5);
        chk("R6 one match pulse", mp_seen, 32'd1);

        // falling and both edges
        enable = 0; wait_n(3);
        edge_sel = 2'd1; load_val = 24'd20; match_val = 24'd1000;
        enable = 1; wait_n(3);
        chk("R5 reload value", count_word, 32'd20);
        pulse(2);
        chk("R3 falling edges", count_word, 32'd22);
        edge_sel = 2'd3; wait_n(2);
        pulse(2);
        chk("R3 both edges", count_word, 32'd26);
        edge_sel = 2'd2; wait_n(2);
        mp_seen = 0; ep_seen = 0;
        pulse(3);
        chk("R4 reserved code count", count_word, 32'd26);
        chk("R4 reserved code pulses", mp_seen + ep_seen, 32'd0);

        // disabled channel holds
        enable = 0; edge_sel = 2'd0; wait_n(2);
        pulse(2);
        chk("R10 hold while disabled", count_word, 32'd26);
        chk("R10 no pulse while disabled", mp_seen + ep_seen, 32'd0);
        enable = 1; wait_n(3);
        chk("R10 re-entry reloads", count_word, 32'd20);

        // prescaler carry
        enable = 0; wait_n(2);
        load_val = 24'h00FFFF; match_val = 24'h010001;
        enable = 1; wait_n(3);
        pulse(1);
        chk("R9 carry into prescaler", count_word, 32'h0001_0000);
        mp_seen = 0;
        pulse(1);
        chk("R9 match across fields", count_word, 32'h0000_FFFF);
        chk("R9 match pulse count", mp_seen, 32'd1);

        // time mode via mode change while enabled
        time_mode = 1; wait_n(8);
        a = count_word;
        wait_n(5);
        chk("R7 free-running step", count_word, a + 32'd5);
        chk("R7 counter cleared on entry", {31'd0, count_word < 32'd20}, 32'd1);
        mp_seen = 0; ep_seen = 0;
        pulse(1);
        chk("R8 one capture", ep_seen, 32'd1);
        chk("R8 captured value", capture_word, {8'd0, m_cap});
        edge_sel = 2'd3; wait_n(2);
        pulse(1);
        chk("R8 both edges capture", ep_seen, 32'd3);
        chk("R11 no match in time mode", mp_seen, 32'd0);
        edge_sel = 2'd2; wait_n(2);
        a = capture_word;
        pulse(2);
        chk("R4 time mode reserved", capture_word, a);
        chk("R9 upper byte zero", {24'd0, capture_word[31:24] | count_word[31:24]}, 32'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule